// File: doc/BRIEF.md
# Interrupt Report Page Scanner

The scanner consumes a byte-per-bit interrupt report region held in a byte-addressed memory. Each reporting unit owns one flag byte in a source area at `SRC_BASE + unit` and a 16-byte status row at `unit * 16`. When the interrupt input pulses, the scanner visits every unit marked present. For each unit whose flag byte is nonzero it clears that byte and reads the unit's event byte. If the event byte is set, it clears that byte too and then raises a dispatch strobe naming the unit and the event bit.

A byte counts as set when it is nonzero. The value 0xFF is the well-formed flag. Any other nonzero value is acted on all the same, and it also raises an error strobe that reports the byte's address and value. Two commands rewrite the two mask bytes at `MASK_BASE`: enable writes 0xFF to both, and disable writes 0x00 to both. The handlers that act on each dispatch sit outside this block.

Top module: `irq_page_scanner`

## Requirements
- R1: While reset is held and just after it is released, `mem_req_o`, `disp_valid_o` and `err_valid_o` are low.
- R2: Once `mem_req_o` is high, it stays high, and `mem_we_o`, `mem_addr_o` and `mem_wdata_o` stay unchanged, until the cycle in which `mem_ack_i` is high. A read's data is taken from `mem_rdata_i` in that same cycle.
- R3: A scan visits present units in a fixed order. Engine positions 0 to N_ENG-1 come first, as unit indices 0 to N_ENG-1. Next comes the primary controller unit (`present_i[N_ENG]`, unit PRI_UNIT = 25). Last comes the secondary controller unit (`present_i[N_ENG+1]`, unit SEC_UNIT = 31). No memory access is made for a unit whose present bit is clear. `present_i` is sampled when the scan starts.
- R4: For each visited unit, the byte at `SRC_BASE + unit` (SRC_BASE = 0x400) is read first. Only when that byte is nonzero is the event byte at `unit*16 + bit` read. The bit is 0 for engine units and 1 for controller units.
- R5: Every byte read as nonzero is written with 0x00 by the very next memory access. Bytes that are not visited keep their contents.
- R6: When a nonzero event byte's clearing write is acknowledged, `disp_valid_o` pulses for the following cycle alone, with `disp_unit_o` and `disp_bit_o` naming that unit and bit. A zero event byte produces no dispatch.
- R7: A read returning a value other than 0x00 or 0xFF pulses `err_valid_o` for one cycle. `err_addr_o` and `err_val_o` carry the address and value of that read. The byte is still cleared and acted on.
- R8: Interrupt pulses that arrive during a scan are remembered, and exactly one further full scan follows once the current scan ends.
- R9: An `en_i` pulse writes 0xFF to MASK_BASE (0x440) and to MASK_BASE+1. A `dis_i` pulse writes 0x00 to both. A pending mask command is carried out before a scan that is pending at the same moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt pulse that requests a scan |
| en_i | input | 1 | Command: set all mask bytes to 0xFF |
| dis_i | input | 1 | Command: set all mask bytes to 0x00 |
| present_i | input | N_ENG+2 | Unit-present bitmap: engines, then primary, then secondary |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 8 | Read data |
| disp_valid_o | output | 1 | Dispatch strobe |
| disp_unit_o | output | UNIT_W | Dispatched unit index |
| disp_bit_o | output | BIT_W | Dispatched event bit |
| err_valid_o | output | 1 | Malformed-byte strobe |
| err_addr_o | output | ADDR_W | Address of the malformed byte |
| err_val_o | output | 8 | Value of the malformed byte |

## Verification
The bench records every memory transaction and compares it with a model that replays the scan order. Any skipped clear, any access to an absent unit, or a controller unit read at the wrong event bit therefore shows up as a sequence mismatch. Flag bytes set to values such as 0x01 or 0x3C catch a design that treats only 0xFF as set, or one that fails to report the error. A unit whose flag byte is set but whose event byte is zero catches a design that dispatches without reading the event byte. Extra interrupt pulses during a scan must produce exactly one rescan, which shows up in the count of flag reads. Giving the mask command and the interrupt in the same cycle shows whether the scan wrongly runs ahead of the mask writes.

// File: rtl/irq_scan_pkg.sv
package irq_scan_pkg;
  localparam logic [7:0] BYTE_FULL = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MASK,
    ST_PICK,
    ST_SRC_RD,
    ST_SRC_CLR,
    ST_EVT_RD,
    ST_EVT_CLR
  } scan_state_e;
endpackage

// File: rtl/irq_unit_picker.sv
module irq_unit_picker #(
  parameter int N     = 6,
  parameter int POS_W = 3
) (
  input  logic [N-1:0]     mask_i,
  input  logic [POS_W-1:0] from_i,
  output logic             found_o,
  output logic [POS_W-1:0] pos_o
);
  // lowest present position at or after from_i
  always_comb begin
    found_o = 1'b0;
    pos_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i] && (POS_W'(i) >= from_i)) begin
        found_o = 1'b1;
        pos_o   = POS_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_byte_eval.sv
module irq_byte_eval
  import irq_scan_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic       set_o,
  output logic       bad_o
);
  assign set_o = (byte_i != 8'h00);
  assign bad_o = set_o && (byte_i != BYTE_FULL);
endmodule

// File: rtl/irq_page_scanner.sv
module irq_page_scanner
  import irq_scan_pkg::*;
#(
  parameter int                N_ENG        = 4,
  parameter int                ADDR_W       = 12,
  parameter int                UNIT_W       = 6,
  parameter int                BIT_W        = 4,
  parameter int                MASK_BYTES   = 2,
  parameter logic [ADDR_W-1:0] SRC_BASE     = 12'h400,
  parameter logic [ADDR_W-1:0] MASK_BASE    = 12'h440,
  parameter logic [UNIT_W-1:0] PRI_UNIT     = 6'd25,
  parameter logic [UNIT_W-1:0] SEC_UNIT     = 6'd31,
  parameter int                ENG_EVT_BIT  = 0,
  parameter int                CTRL_EVT_BIT = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                irq_i,
  input  logic                en_i,
  input  logic                dis_i,
  input  logic [N_ENG+1:0]    present_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [7:0]          mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [7:0]          mem_rdata_i,
  output logic                disp_valid_o,
  output logic [UNIT_W-1:0]   disp_unit_o,
  output logic [BIT_W-1:0]    disp_bit_o,
  output logic                err_valid_o,
  output logic [ADDR_W-1:0]   err_addr_o,
  output logic [7:0]          err_val_o
);
  localparam int N_UNITS = N_ENG + 2;
  localparam int POS_W   = $clog2(N_UNITS + 1);
  localparam int MB_W    = (MASK_BYTES > 1) ? $clog2(MASK_BYTES) : 1;

  scan_state_e          state_q;
  logic [POS_W-1:0]     pos_q;
  logic [N_UNITS-1:0]   prs_q;
  logic                 irq_pend_q, cmd_pend_q, cmd_val_q, wval_q;
  logic [MB_W-1:0]      mb_q;
  logic                 disp_valid_q, err_valid_q;
  logic [UNIT_W-1:0]    disp_unit_q;
  logic [BIT_W-1:0]     disp_bit_q;
  logic [ADDR_W-1:0]    err_addr_q;
  logic [7:0]           err_val_q;

  logic                 found;
  logic [POS_W-1:0]     found_pos;
  logic                 rd_set, rd_bad;
  logic [UNIT_W-1:0]    unit_idx;
  logic [BIT_W-1:0]     evt_bit;
  logic [ADDR_W-1:0]    src_addr, evt_addr;
  logic                 cmd_now, mask_go, start;

  irq_unit_picker #(.N(N_UNITS), .POS_W(POS_W)) i_picker (
    .mask_i (prs_q),
    .from_i (pos_q),
    .found_o(found),
    .pos_o  (found_pos)
  );

  irq_byte_eval i_eval (
    .byte_i(mem_rdata_i),
    .set_o (rd_set),
    .bad_o (rd_bad)
  );

  always_comb begin
    if (pos_q < POS_W'(N_ENG)) begin
      unit_idx = UNIT_W'(pos_q);
      evt_bit  = BIT_W'(ENG_EVT_BIT);
    end else if (pos_q == POS_W'(N_ENG)) begin
      unit_idx = PRI_UNIT;
      evt_bit  = BIT_W'(CTRL_EVT_BIT);
    end else begin
      unit_idx = SEC_UNIT;
      evt_bit  = BIT_W'(CTRL_EVT_BIT);
    end
  end

  assign src_addr = SRC_BASE + ADDR_W'(unit_idx);
  assign evt_addr = (ADDR_W'(unit_idx) << BIT_W) | ADDR_W'(evt_bit);

  assign cmd_now = en_i | dis_i;
  assign mask_go = (state_q == ST_IDLE) && (cmd_pend_q | cmd_now);
  assign start   = (state_q == ST_IDLE) && !(cmd_pend_q | cmd_now) && (irq_pend_q | irq_i);

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = src_addr;
    mem_wdata_o = 8'h00;
    case (state_q)
      ST_MASK: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = MASK_BASE + ADDR_W'(mb_q);
        mem_wdata_o = wval_q ? BYTE_FULL : 8'h00;
      end
      ST_SRC_RD:  ;
      ST_SRC_CLR: mem_we_o = 1'b1;
      ST_EVT_RD:  mem_addr_o = evt_addr;
      ST_EVT_CLR: begin
        mem_we_o   = 1'b1;
        mem_addr_o = evt_addr;
      end
      default: mem_req_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      pos_q        <= '0;
      prs_q        <= '0;
      irq_pend_q   <= 1'b0;
      cmd_pend_q   <= 1'b0;
      cmd_val_q    <= 1'b0;
      wval_q       <= 1'b0;
      mb_q         <= '0;
      disp_valid_q <= 1'b0;
      disp_unit_q  <= '0;
      disp_bit_q   <= '0;
      err_valid_q  <= 1'b0;
      err_addr_q   <= '0;
      err_val_q    <= '0;
    end else begin
      disp_valid_q <= 1'b0;
      err_valid_q  <= 1'b0;
      irq_pend_q   <= start ? 1'b0 : (irq_pend_q | irq_i);
      if (mask_go) begin
        wval_q     <= cmd_now ? ~dis_i : cmd_val_q;
        cmd_pend_q <= 1'b0;
      end
      if (cmd_now && !mask_go) begin
        cmd_pend_q <= 1'b1;
        cmd_val_q  <= ~dis_i;
      end
      case (state_q)
        ST_IDLE: begin
          if (mask_go) begin
            state_q <= ST_MASK;
            mb_q    <= '0;
          end else if (start) begin
            prs_q   <= present_i;
            pos_q   <= '0;
            state_q <= ST_PICK;
          end
        end
        ST_MASK: if (mem_ack_i) begin
          if (mb_q == MB_W'(MASK_BYTES - 1)) state_q <= ST_IDLE;
          else mb_q <= mb_q + 1'b1;
        end
        ST_PICK: begin
          if (found) begin
            pos_q   <= found_pos;
            state_q <= ST_SRC_RD;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_SRC_RD, ST_EVT_RD: if (mem_ack_i) begin
          if (rd_set) begin
            err_valid_q <= rd_bad;
            err_addr_q  <= mem_addr_o;
            err_val_q   <= mem_rdata_i;
            state_q     <= (state_q == ST_SRC_RD) ? ST_SRC_CLR : ST_EVT_CLR;
          end else begin
            pos_q   <= pos_q + 1'b1;
            state_q <= ST_PICK;
          end
        end
        ST_SRC_CLR: if (mem_ack_i) state_q <= ST_EVT_RD;
        ST_EVT_CLR: if (mem_ack_i) begin
          disp_valid_q <= 1'b1;
          disp_unit_q  <= unit_idx;
          disp_bit_q   <= evt_bit;
          pos_q        <= pos_q + 1'b1;
          state_q      <= ST_PICK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign disp_valid_o = disp_valid_q;
  assign disp_unit_o  = disp_unit_q;
  assign disp_bit_o   = disp_bit_q;
  assign err_valid_o  = err_valid_q;
  assign err_addr_o   = err_addr_q;
  assign err_val_o    = err_val_q;
endmodule

// File: rtl/irq_scan_checker.sv
module irq_scan_checker #(
  parameter int                ADDR_W    = 12,
  parameter int                BIT_W     = 4,
  parameter logic [ADDR_W-1:0] SRC_BASE  = 12'h400,
  parameter logic [ADDR_W-1:0] MASK_BASE = 12'h440
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [7:0]        mem_wdata_o,
  input logic              mem_ack_i,
  input logic              disp_valid_o,
  input logic [BIT_W-1:0]  disp_bit_o,
  input logic              err_valid_o,
  input logic [7:0]        err_val_o
);
  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                && $stable(mem_wdata_o));

  assert_clear_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && (mem_addr_o < MASK_BASE) |-> mem_wdata_o == 8'h00);

  assert_disp_after_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> $past(mem_req_o && mem_we_o && mem_ack_i && (mem_addr_o < SRC_BASE))
                     && ($past(mem_addr_o[BIT_W-1:0]) == disp_bit_o));

  assert_disp_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |=> !disp_valid_o);

  assert_err_value_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> (err_val_o != 8'h00) && (err_val_o != 8'hFF));

  assert_err_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |=> !err_valid_o);
endmodule

bind irq_page_scanner irq_scan_checker #(
  .ADDR_W(ADDR_W), .BIT_W(BIT_W), .SRC_BASE(SRC_BASE), .MASK_BASE(MASK_BASE)
) i_scan_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .disp_valid_o(disp_valid_o), .disp_bit_o(disp_bit_o),
  .err_valid_o(err_valid_o), .err_val_o(err_val_o)
);

// File: tb/test_irq_page_scanner.sv
module test_irq_page_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int N_ENG = 4;
  localparam int NU = N_ENG + 2;
  localparam int MEM_SZ = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq = 1'b0, en = 1'b0, dis = 1'b0;
  logic [NU-1:0] present = '0;
  logic req, we, ack = 1'b0;
  logic [11:0] addr;
  logic [7:0] wdata, rdata;
  logic disp_v, err_v;
  logic [5:0] disp_u;
  logic [3:0] disp_b;
  logic [11:0] err_a;
  logic [7:0] err_d;

  logic [7:0] mem [0:MEM_SZ-1];
  logic [7:0] shadow [0:MEM_SZ-1];

  logic [20:0] got_acc[$], exp_acc[$];
  logic [9:0] got_disp[$], exp_disp[$];
  logic [19:0] got_err[$], exp_err[$];

  int checks = 0, failures = 0, hs_viol = 0, disp_viol = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_page_scanner i_irq_page_scanner (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .en_i(en), .dis_i(dis),
    .present_i(present), .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_ack_i(ack), .mem_rdata_i(rdata),
    .disp_valid_o(disp_v), .disp_unit_o(disp_u), .disp_bit_o(disp_b),
    .err_valid_o(err_v), .err_addr_o(err_a), .err_val_o(err_d)
  );

  assign rdata = mem[addr[10:0]];

  always @(posedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else ack <= req && !ack && ($urandom_range(2) != 0);
    if (req && we && ack) mem[addr[10:0]] <= wdata;
  end

  logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [11:0] p_addr = '0;
  logic [7:0]  p_wd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_req && !p_ack && !(req && we == p_we && addr == p_addr && wdata == p_wd))
        hs_viol++;
      if (req && ack) got_acc.push_back({we, addr, we ? wdata : rdata});
      if (disp_v) begin
        got_disp.push_back({disp_u, disp_b});
        if (mem[{disp_u, disp_b}] != 8'h00) disp_viol++;
      end
      if (err_v) got_err.push_back({err_a, err_d});
    end
    p_req = req; p_ack = ack; p_we = we; p_addr = addr; p_wd = wdata;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] unit_of(input int p);
    if (p < N_ENG) return 6'(p);
    return (p == N_ENG) ? 6'd25 : 6'd31;
  endfunction

  function automatic logic [3:0] bit_of(input int p);
    return (p < N_ENG) ? 4'd0 : 4'd1;
  endfunction

  task automatic poke(input int a, input logic [7:0] v);
    mem[a] = v;
    shadow[a] = v;
  endtask

  task automatic model_byte(input logic [11:0] a, output logic set);
    logic [7:0] v;
    v = shadow[a[10:0]];
    exp_acc.push_back({1'b0, a, v});
    set = (v != 8'h00);
    if (set) begin
      if (v != 8'hFF) exp_err.push_back({a, v});
      exp_acc.push_back({1'b1, a, 8'h00});
      shadow[a[10:0]] = 8'h00;
    end
  endtask

  task automatic model_scan(input logic [NU-1:0] prs);
    logic s;
    for (int p = 0; p < NU; p++) begin
      if (prs[p]) begin
        model_byte(12'h400 + 12'(unit_of(p)), s);
        if (s) begin
          model_byte({2'b00, unit_of(p), bit_of(p)}, s);
          if (s) exp_disp.push_back({unit_of(p), bit_of(p)});
        end
      end
    end
  endtask

  task automatic model_mask(input logic [7:0] v);
    for (int k = 0; k < 2; k++) begin
      exp_acc.push_back({1'b1, 12'h440 + 12'(k), v});
      shadow[12'h440 + k] = v;
    end
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 40) begin
      @(negedge clk);
      q = (req || disp_v || err_v) ? 0 : q + 1;
    end
  endtask

  task automatic pulse(input bit i, input bit e, input bit d);
    @(negedge clk);
    irq = i; en = e; dis = d;
    @(negedge clk);
    irq = 0; en = 0; dis = 0;
  endtask

  task automatic compare(input string tag);
    int bad = 0;
    check({tag, " R3 access count"}, 32'(got_acc.size()), 32'(exp_acc.size()));
    for (int i = 0; i < exp_acc.size() && i < got_acc.size(); i++)
      if (got_acc[i] !== exp_acc[i]) begin
        if (bad == 0) check({tag, " R4 R5 access sequence"}, 32'(got_acc[i]), 32'(exp_acc[i]));
        bad++;
      end
    check({tag, " R6 dispatch count"}, 32'(got_disp.size()), 32'(exp_disp.size()));
    for (int i = 0; i < exp_disp.size() && i < got_disp.size(); i++)
      check({tag, " R6 dispatch unit/bit"}, 32'(got_disp[i]), 32'(exp_disp[i]));
    check({tag, " R7 error count"}, 32'(got_err.size()), 32'(exp_err.size()));
    for (int i = 0; i < exp_err.size() && i < got_err.size(); i++)
      check({tag, " R7 error addr/value"}, 32'(got_err[i]), 32'(exp_err[i]));
    bad = 0;
    for (int a = 0; a < 12'h450; a++) if (mem[a] !== shadow[a]) bad++;
    check({tag, " R5 memory image mismatches"}, 32'(bad), 0);
    got_acc.delete(); exp_acc.delete();
    got_disp.delete(); exp_disp.delete();
    got_err.delete(); exp_err.delete();
  endtask

  function automatic logic [7:0] rnd_byte();
    case ($urandom_range(3))
      0: return 8'h00;
      1, 2: return 8'hFF;
      default: return 8'($urandom_range(255));
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < MEM_SZ; a++) begin mem[a] = 8'h00; shadow[a] = 8'h00; end
    #(CLK_PERIOD * 3);
    check("R1 req in reset", 32'(req), 0);
    check("R1 disp in reset", 32'(disp_v), 0);
    check("R1 err in reset", 32'(err_v), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 req after reset", 32'(req), 0);

    // enable command
    pulse(0, 1, 0); model_mask(8'hFF); wait_quiet();
    check("R9 mask byte0 enabled", 32'(mem[12'h440]), 32'hFF);
    check("R9 mask byte1 enabled", 32'(mem[12'h441]), 32'hFF);
    compare("enable");

    // directed image
    present = 6'b01_1111;
    poke(12'h400, 8'hFF); poke(12'h000, 8'hFF);
    poke(12'h401, 8'h3C); poke(12'h010, 8'h01); poke(12'h011, 8'hFF);
    poke(12'h402, 8'h00); poke(12'h020, 8'hFF);
    poke(12'h403, 8'hFF); poke(12'h030, 8'h00);
    poke(12'h400 + 25, 8'hFF); poke(25 * 16 + 1, 8'h80); poke(25 * 16, 8'hFF);
    poke(12'h400 + 31, 8'hFF); poke(31 * 16 + 1, 8'hFF);
    pulse(1, 0, 0); model_scan(present); wait_quiet();
    check("R4 engine2 status untouched", 32'(mem[12'h020]), 32'hFF);
    check("R3 absent secondary source untouched", 32'(mem[12'h400 + 31]), 32'hFF);
    check("R4 primary bit0 untouched", 32'(mem[25 * 16]), 32'hFF);
    compare("directed");

    // random rounds
    for (int r = 0; r < 10; r++) begin
      present = NU'($urandom_range((1 << NU) - 1));
      for (int p = 0; p < NU; p++) begin
        poke(12'h400 + 12'(unit_of(p)), rnd_byte());
        poke({unit_of(p), bit_of(p)}, rnd_byte());
        poke({unit_of(p), bit_of(p) ^ 4'd2}, rnd_byte());
      end
      pulse(1, 0, 0); model_scan(present); wait_quiet();
      compare("random");
    end

    // pulses during a scan give exactly one more scan
    present = 6'b11_1111;
    for (int p = 0; p < NU; p++) begin
      poke(12'h400 + 12'(unit_of(p)), 8'hFF);
      poke({unit_of(p), bit_of(p)}, 8'hFF);
    end
    pulse(1, 0, 0);
    while (!req) @(negedge clk);
    pulse(1, 0, 0);
    repeat (3) @(negedge clk);
    pulse(1, 0, 0);
    model_scan(present); model_scan(present); wait_quiet();
    compare("R8 rescan");

    // mask command and interrupt together: mask first
    poke(12'h402, 8'h11); poke(12'h020, 8'hFF);
    pulse(1, 0, 1); model_mask(8'h00); model_scan(present); wait_quiet();
    check("R9 mask byte0 disabled", 32'(mem[12'h440]), 0);
    check("R9 mask byte1 disabled", 32'(mem[12'h441]), 0);
    compare("R9 mask before scan");

    check("R2 handshake held until ack", 32'(hs_viol), 0);
    check("R6 event byte cleared before dispatch", 32'(disp_viol), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule